// File: doc/BRIEF.md
# ADC Result Window Detector

This block sits beside a converter and inspects each finished conversion without processor help. Software loads a lower bound and an upper bound. When a result lies strictly above the lower bound and strictly below the upper bound, the block sets a sticky in-window flag. That flag drives an interrupt request and stays high until software clears it.

The converter presents a one-cycle done strobe together with a 16-bit data word. The word holds one of three result formats:
- an 8-bit result in the low byte;
- a 12-bit result in the low bits (right-justified);
- a 12-bit result in the high bits (left-justified).

Bounds are written one byte at a time through a small register port. They use the same justification as the data word.

Top module: `adc_win_detect`

## Requirements
- R1: After reset the in-window flag is 0 and both bounds are 0x0000, so no result can set the flag until bounds are written.
- R2: A register write with `reg_we_i` high stores `reg_wdata_i` on the clock edge, as follows:
  - address 0 writes the lower-bound low byte;
  - address 1 writes the lower-bound high byte;
  - address 2 writes the upper-bound low byte;
  - address 3 writes the upper-bound high byte.
- R3: Mode 0 (8-bit) compares `conv_data_i[7:0]` against the high bytes of the two bounds only. With high bytes 0x10 and 0x20, results 0x11 to 0x1F set the flag and 0x10 and 0x20 do not. The data high byte and the bound low bytes are ignored.
- R4: Mode 1 (12-bit right-justified) compares `conv_data_i[11:0]` with bits [15:12] forced to zero against the full 16-bit bounds, strictly. Mode 3 behaves the same as mode 1.
- R5: Mode 2 (12-bit left-justified) compares `conv_data_i[15:4]` with bits [3:0] forced to zero against the full 16-bit bounds, strictly. For example, with bounds 0x1000 and 0x2000, data 0x1008 does not set the flag.
- R6: A strobe sampled on clock edge k is compared on edge k+1. The flag is therefore visible after edge k+1 and not after edge k.
- R7: Once set, the flag stays 1 through any number of later results that fall outside the window.
- R8: A write to address 4 clears the flag whatever the data value. If a hit is recorded on the same edge as the clear, the flag stays 1.
- R9: When the lower bound is not below the upper bound, no result sets the flag.
- R10: Changes on `conv_data_i` while `conv_done_i` is low have no effect on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_done_i | input | 1 | One-cycle conversion-complete strobe |
| conv_data_i | input | 16 | Conversion data word |
| res_mode_i | input | 2 | Result format: 0 is 8-bit, 1 and 3 are 12-bit right-justified, 2 is 12-bit left-justified |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 3 | Register address: 0–3 are bound bytes, 4 clears the flag |
| reg_wdata_i | input | 8 | Register write data |
| win_irq_o | output | 1 | Sticky in-window flag and interrupt request |

## Verification
The assertions assume the following about the inputs:
- `conv_done_i` is a clean synchronous pulse;
- `res_mode_i` is stable while the strobe is high;
- bounds are not rewritten during the cycle in which a captured result is being compared.

The stimulus writes all bounds before it issues any strobe. Each conversion is a one-cycle pulse followed by an idle cycle. The only overlap between a clear and a compare is the single R8 case, which the bench schedules deliberately.

// File: rtl/adc_win_pkg.sv
package adc_win_pkg;
  typedef enum logic [1:0] {
    MODE_NARROW    = 2'b00,
    MODE_RIGHT     = 2'b01,
    MODE_LEFT      = 2'b10,
    MODE_RIGHT_ALT = 2'b11
  } res_mode_e;
endpackage

// File: rtl/adc_win_regs.sv
module adc_win_regs #(
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [WORD_W-1:0] gt_o,
  output logic [WORD_W-1:0] lt_o,
  output logic              clr_o
);
  localparam int NBYTES   = WORD_W / BYTE_W;
  localparam int LT_BASE  = NBYTES;
  localparam int CLR_ADDR = 2 * NBYTES;

  logic [WORD_W-1:0] gt_q, lt_q;

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        gt_q[i*BYTE_W +: BYTE_W] <= '0;
      end else if (we_i && addr_i == ADDR_W'(i)) begin
        gt_q[i*BYTE_W +: BYTE_W] <= wdata_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lt_q[i*BYTE_W +: BYTE_W] <= '0;
      end else if (we_i && addr_i == ADDR_W'(LT_BASE + i)) begin
        lt_q[i*BYTE_W +: BYTE_W] <= wdata_i;
      end
    end
  end

  assign gt_o  = gt_q;
  assign lt_o  = lt_q;
  assign clr_o = we_i && (addr_i == ADDR_W'(CLR_ADDR));

  AST_LIMIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(gt_q) && $stable(lt_q))); // R2
endmodule

// File: rtl/adc_win_justify.sv
module adc_win_justify
  import adc_win_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int RES_W    = 12,
  parameter int NARROW_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [WORD_W-1:0] data_i,
  input  res_mode_e         mode_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] word_o,
  output res_mode_e         mode_o
);
  localparam int PAD_W = WORD_W - RES_W;
  localparam logic [WORD_W-1:0] MASK_RIGHT  = {{PAD_W{1'b0}}, {RES_W{1'b1}}};
  localparam logic [WORD_W-1:0] MASK_LEFT   = {{RES_W{1'b1}}, {PAD_W{1'b0}}};
  localparam logic [WORD_W-1:0] MASK_NARROW = {{(WORD_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [WORD_W-1:0] mask;
  logic [WORD_W-1:0] word_q;
  logic              valid_q;
  res_mode_e         mode_q;

  always_comb begin
    unique case (mode_i)
      MODE_NARROW: mask = MASK_NARROW;
      MODE_LEFT:   mask = MASK_LEFT;
      default:     mask = MASK_RIGHT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      word_q  <= '0;
      mode_q  <= MODE_NARROW;
    end else begin
      valid_q <= done_i;
      if (done_i) begin
        word_q <= data_i & mask;
        mode_q <= mode_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign word_o  = word_q;
  assign mode_o  = mode_q;

  AST_WORD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> ($stable(word_q) && !valid_q)); // R10
endmodule

// File: rtl/adc_win_cmp.sv
module adc_win_cmp
  import adc_win_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] word_i,
  input  res_mode_e         mode_i,
  input  logic [WORD_W-1:0] gt_i,
  input  logic [WORD_W-1:0] lt_i,
  input  logic              clr_i,
  output logic              flag_o
);
  localparam int ZPAD_W = WORD_W - NARROW_W;

  logic [WORD_W-1:0] gt_eff, lt_eff;
  logic              hit;
  logic              flag_q;

  // narrow results compare against the upper byte of each bound only
  always_comb begin
    if (mode_i == MODE_NARROW) begin
      gt_eff = {{ZPAD_W{1'b0}}, gt_i[WORD_W-1 -: NARROW_W]};
      lt_eff = {{ZPAD_W{1'b0}}, lt_i[WORD_W-1 -: NARROW_W]};
    end else begin
      gt_eff = gt_i;
      lt_eff = lt_i;
    end
  end

  assign hit = valid_i && (gt_eff < word_i) && (word_i < lt_eff);

  // a hit outranks a clear on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (hit)    flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  AST_SET_NEEDS_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(valid_i)); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q); // R7
  AST_CLEAR_WORKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !valid_i) |=> !flag_q); // R8
  AST_EMPTY_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && (gt_eff >= lt_eff)) |=> !flag_q); // R9
endmodule

// File: rtl/adc_win_detect.sv
module adc_win_detect
  import adc_win_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int RES_W    = 12,
  parameter int NARROW_W = 8,
  parameter int BYTE_W   = 8,
  parameter int ADDR_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_done_i,
  input  logic [WORD_W-1:0] conv_data_i,
  input  logic [1:0]        res_mode_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic              win_irq_o
);
  logic [WORD_W-1:0] gt_w, lt_w, word_w;
  logic              clr_w, valid_w;
  res_mode_e         mode_w;

  adc_win_regs #(
    .WORD_W(WORD_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .gt_o    (gt_w),
    .lt_o    (lt_w),
    .clr_o   (clr_w)
  );

  adc_win_justify #(
    .WORD_W(WORD_W), .RES_W(RES_W), .NARROW_W(NARROW_W)
  ) u_just (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .done_i  (conv_done_i),
    .data_i  (conv_data_i),
    .mode_i  (res_mode_e'(res_mode_i)),
    .valid_o (valid_w),
    .word_o  (word_w),
    .mode_o  (mode_w)
  );

  adc_win_cmp #(
    .WORD_W(WORD_W), .NARROW_W(NARROW_W)
  ) u_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_w),
    .word_i  (word_w),
    .mode_i  (mode_w),
    .gt_i    (gt_w),
    .lt_i    (lt_w),
    .clr_i   (clr_w),
    .flag_o  (win_irq_o)
  );

  AST_IDLE_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!conv_done_i && !win_irq_o) |=> !$rose(valid_w)); // R10
endmodule

// File: tb/tb_adc_win_detect.sv
module tb_adc_win_detect;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        conv_done_i = 1'b0;
  logic [15:0] conv_data_i = '0;
  logic [1:0]  res_mode_i = '0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic        win_irq_o;

  always #5 clk_i = ~clk_i;

  adc_win_detect dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .conv_done_i(conv_done_i),
    .conv_data_i(conv_data_i), .res_mode_i(res_mode_i),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .win_irq_o(win_irq_o)
  );

  typedef struct {
    int    due;
    logic  exp;
    string tag;
  } item_t;

  item_t       sb_q[$];
  int          cyc = 0;
  int          n_chk = 0;
  int          n_bad = 0;
  logic [15:0] m_gt = '0;
  logic [15:0] m_lt = '0;
  logic        m_flag = 1'b0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic check(logic act, logic exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: win_irq_o=%0b expected %0b", tag, act, exp);
    end
  endtask

  // monitor: pop scoreboard items as their sample cycle arrives
  always @(negedge clk_i) begin
    item_t it;
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      it = sb_q.pop_front();
      check(win_irq_o, it.exp, it.tag);
    end
  end

  function automatic logic model_hit(logic [1:0] m, logic [15:0] d);
    logic [15:0] dv, g, l;
    case (m)
      2'b00: begin dv = {8'h00, d[7:0]}; g = {8'h00, m_gt[15:8]}; l = {8'h00, m_lt[15:8]}; end
      2'b10: begin dv = d & 16'hFFF0; g = m_gt; l = m_lt; end
      default: begin dv = d & 16'h0FFF; g = m_gt; l = m_lt; end
    endcase
    return (g < dv) && (dv < l);
  endfunction

  task automatic wr(logic [2:0] a, logic [7:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    case (a)
      3'd0: m_gt[7:0]  = d;
      3'd1: m_gt[15:8] = d;
      3'd2: m_lt[7:0]  = d;
      3'd3: m_lt[15:8] = d;
      default: ;
    endcase
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic set_limits(logic [15:0] g, logic [15:0] l);
    wr(3'd0, g[7:0]); wr(3'd1, g[15:8]);
    wr(3'd2, l[7:0]); wr(3'd3, l[15:8]);
  endtask

  task automatic clear_flag(string tag);
    wr(3'd4, 8'hA5);
    m_flag = 1'b0;
    check(win_irq_o, 1'b0, tag);
  endtask

  // driver: one-cycle strobe, one idle cycle; expectation due two edges later
  task automatic conv(logic [1:0] m, logic [15:0] d, string tag);
    item_t it;
    m_flag = m_flag | model_hit(m, d);
    conv_done_i = 1'b1; conv_data_i = d; res_mode_i = m;
    it.due = cyc + 2; it.exp = m_flag; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk_i);
    conv_done_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(win_irq_o, 1'b0, "R1 reset flag");
    rst_ni = 1'b1;
    @(negedge clk_i);
    conv(2'b00, 16'h0005, "R1 zero bounds");
    conv(2'b01, 16'h0000, "R1 zero bounds 12b");

    // R2/R3: high bytes 0x10/0x20, low bytes are junk that must be ignored
    set_limits(16'h10FF, 16'h2000);
    conv(2'b00, 16'h0010, "R3 at lower bound");
    conv(2'b00, 16'h0020, "R3 at upper bound");
    conv(2'b00, 16'h000F, "R3 below");
    conv(2'b00, 16'h0021, "R3 above");
    conv(2'b00, 16'h0011, "R3 first inside");
    conv(2'b00, 16'h0030, "R7 sticky outside");
    conv(2'b00, 16'h00FF, "R7 sticky max");
    clear_flag("R8 clear");
    conv(2'b00, 16'hAB1F, "R3 high byte ignored");
    clear_flag("R8 clear again");

    // R6 latency, checked directly
    conv_done_i = 1'b1; conv_data_i = 16'h0015; res_mode_i = 2'b00;
    @(negedge clk_i);
    conv_done_i = 1'b0;
    check(win_irq_o, 1'b0, "R6 not yet after capture edge");
    @(negedge clk_i);
    check(win_irq_o, 1'b1, "R6 set after compare edge");
    m_flag = 1'b1;
    clear_flag("R8 clear after R6");

    // R8 hit and clear on the same edge: set wins
    conv_done_i = 1'b1; conv_data_i = 16'h0018; res_mode_i = 2'b00;
    @(negedge clk_i);
    conv_done_i = 1'b0;
    reg_we_i = 1'b1; reg_addr_i = 3'd4; reg_wdata_i = 8'h00;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    check(win_irq_o, 1'b1, "R8 hit beats clear");
    m_flag = 1'b1;
    clear_flag("R8 clear with zero data");

    // R4 right-justified 12-bit
    set_limits(16'h0100, 16'h0200);
    conv(2'b01, 16'h0100, "R4 at lower");
    conv(2'b01, 16'h0200, "R4 at upper");
    conv(2'b01, 16'hF0FF, "R4 masked below");
    conv(2'b01, 16'hF150, "R4 top nibble ignored");
    clear_flag("R8 clear R4");
    conv(2'b11, 16'h0101, "R4 mode 3 as right");
    clear_flag("R8 clear R4 alt");

    // R5 left-justified 12-bit
    set_limits(16'h1000, 16'h2000);
    conv(2'b10, 16'h1000, "R5 at lower");
    conv(2'b10, 16'h2000, "R5 at upper");
    conv(2'b10, 16'h1008, "R5 low nibble ignored");
    conv(2'b10, 16'h1FF0, "R5 top inside");
    clear_flag("R8 clear R5");
    conv(2'b10, 16'h1010, "R5 first inside");
    clear_flag("R8 clear R5 again");

    // R9 empty window
    set_limits(16'h2000, 16'h1000);
    conv(2'b10, 16'h1800, "R9 inverted bounds");
    set_limits(16'h1800, 16'h1800);
    conv(2'b10, 16'h1800, "R9 equal bounds");
    conv(2'b10, 16'h17F0, "R9 equal bounds below");

    // R10 data changes without strobe
    set_limits(16'h1000, 16'h2000);
    res_mode_i = 2'b10;
    for (int i = 0; i < 3; i++) begin
      conv_data_i = 16'h1800 + 16'(i * 16);
      @(negedge clk_i);
    end
    @(negedge clk_i);
    check(win_irq_o, 1'b0, "R10 no strobe no set");

    repeat (4) @(negedge clk_i);
    if (sb_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL scoreboard: %0d items left, expected 0", sb_q.size());
    end
    summary();
  end
endmodule